// File: doc/BRIEF.md
# Bus Agent Request Issue Controller

This block sits inside a symmetric agent on a shared system bus and decides the cycle in which the agent may put its next queued transaction on the bus. It reads three active-low bus conditions: a bus-initialization line, a stall line raised by any agent that cannot take new work, and a priority-agent request line. It also reads a power-on strap that decides whether bus-initialization is honoured at all. The bus condition lines are captured only on a sampling strobe that a divider produces every `STROBE_DIV` clocks. The controller acts on the captured values in the cycle after the strobe.

Internally the controller runs a three-state symmetric arbitration machine (idle, requesting, owning), a lock flag for locked sequences, and a counter of issued transactions that have not yet completed. A bus-initialization event performs a partial reset. It returns arbitration and lock to idle but leaves the outstanding count alone, so the agent re-arbitrates and then carries on with its pending work. The priority agent overrides symmetric issue, except for a request that belongs to a locked sequence already in progress.

Top module: `issue_ctrl`

## Requirements
- R1: After reset, `issue_grant` is 0, `arb_state` is 0 (idle), `lock_active` is 0 and `oq_count` is 0. The state encoding is 0 = idle, 1 = requesting, 2 = owner.
- R2: The control lines are captured only at the end of every `STROBE_DIV`-th clock cycle after reset. The first capture edge ends cycle `STROBE_DIV`. A pulse that falls entirely between capture edges has no effect. With `req_pending` held, no stall or priority, and a completion in every cycle, grants come exactly `STROBE_DIV` cycles apart.
- R3: When `init_obs_en` is 1 and the bus-init line is captured low, the arbitration state goes to idle and `lock_active` goes to 0 in the cycle after the capture edge.
- R4: A bus-init event never changes `oq_count`.
- R5: When `init_obs_en` is 0, a bus-init assertion changes neither the lock flag nor the outstanding count, and it does not reset arbitration.
- R6: No grant is issued in a decision slot whose captured stall line was low.
- R7: No grant is issued while the priority line is captured low, unless `lock_active` is 1 and `req_is_locked` is 1.
- R8: `oq_count` rises by one per grant and falls by one per `cpl` cycle. A grant and a completion in the same cycle cancel. `cpl` at zero is ignored. The count never exceeds `OQ_DEPTH`, and no grant is issued while it equals `OQ_DEPTH`.
- R9: In the owner state with a request pending, `HOLD_LIMIT` consecutive decision slots that are blocked by stall, priority or a full queue send the machine back to the requesting state. Without a pending request, the owner and requesting states fall back to idle.
- R10: After a bus-init event, with requests still pending, the agent passes through requesting to owner again and grants resume.
- R11: `lock_start` sets the lock flag. `lock_end` clears it and wins over `lock_start` in the same cycle. An enabled bus-init event clears it ahead of both.
- R12: `issue_grant` is a one-cycle pulse. It is issued at most once per strobe period and only while `arb_state` is owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_obs_en | input | 1 | Power-on strap, 1 = honour bus-init |
| bus_init_n | input | 1 | Bus initialization, active low |
| stall_n | input | 1 | Block-next-request stall, active low |
| prio_n | input | 1 | Priority agent request, active low |
| req_pending | input | 1 | Agent has a queued transaction to issue |
| req_is_locked | input | 1 | Pending transaction belongs to the current locked sequence |
| lock_start | input | 1 | Locked sequence begins |
| lock_end | input | 1 | Locked sequence ends |
| cpl | input | 1 | One outstanding transaction completed |
| issue_grant | output | 1 | One-cycle permission to issue the next transaction |
| arb_state | output | 2 | Arbitration state (0 idle, 1 requesting, 2 owner) |
| lock_active | output | 1 | Locked sequence in progress |
| oq_count | output | clog2(OQ_DEPTH+1) | Outstanding transaction count |

## Verification
The bench goes after four corner cases.

- **Bus-init while the queue is full.** A controller that treats bus-init as a full reset would drop `oq_count` to zero here, and would then over-issue past the real queue depth.
- **Bus-init glitch between capture edges.** A one-cycle bus-init pulse is placed between capture edges. A design that samples on every clock would then lose its lock.
- **Strap disabled.** Bus-init is held with the strap at 0. A design that ignores the strap would clear the lock.
- **Priority override with and without a locked request.** A design that drops the locked-sequence exception would starve the lock holder. One that ignores priority would keep granting while the priority agent owns the bus.

Random segments are compared cycle by cycle against a bench model. They also cover the hold-limit fallback and full-queue stalls.

// File: rtl/issue_ctrl_pkg.sv
package issue_ctrl_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_REQ  = 2'd1,
        ARB_OWN  = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic init;
        logic stall;
        logic prio;
    } bus_smp_t;

    function automatic logic issue_blocked(
        input bus_smp_t smp,
        input logic     lock,
        input logic     locked_req,
        input logic     full
    );
        return smp.stall | (smp.prio & ~(lock & locked_req)) | full;
    endfunction

endpackage

// File: rtl/issue_strobe.sv
module issue_strobe #(
    parameter int STROBE_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic stb,
    output logic act
);
    localparam int CW = (STROBE_DIV > 1) ? $clog2(STROBE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(STROBE_DIV - 1);

    logic [CW-1:0] cnt;

    assign stb = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            act <= 1'b0;
        end else begin
            cnt <= stb ? '0 : cnt + 1'b1;
            act <= stb;
        end
    end
endmodule

// File: rtl/issue_sampler.sv
module issue_sampler
    import issue_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb,
    input  logic     init_obs_en,
    input  logic     bus_init_n,
    input  logic     stall_n,
    input  logic     prio_n,
    output bus_smp_t smp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else if (stb) begin
            smp.init  <= init_obs_en & ~bus_init_n;
            smp.stall <= ~stall_n;
            smp.prio  <= ~prio_n;
        end
    end
endmodule

// File: rtl/issue_queue_ctr.sv
module issue_queue_ctr #(
    parameter int OQ_DEPTH = 8,
    localparam int CW = $clog2(OQ_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam logic [CW-1:0] TOP = CW'(OQ_DEPTH);

    assign full = (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && !dec && !full) begin
            count <= count + 1'b1;
        end else if (dec && !inc && count != '0) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/issue_arb.sv
module issue_arb
    import issue_ctrl_pkg::*;
#(
    parameter int HOLD_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act,
    input  bus_smp_t   smp,
    input  logic       req_pending,
    input  logic       req_is_locked,
    input  logic       lock_start,
    input  logic       lock_end,
    input  logic       full,
    output arb_state_e state,
    output logic       lock,
    output logic       grant
);
    localparam int HW = $clog2(HOLD_LIMIT + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_LIMIT - 1);

    logic [HW-1:0] hold;
    logic          blocked;

    assign blocked = issue_blocked(smp, lock, req_is_locked, full);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
            hold  <= '0;
            lock  <= 1'b0;
            grant <= 1'b0;
        end else begin
            grant <= 1'b0;

            if (act && smp.init) begin
                lock <= 1'b0;
            end else if (lock_end) begin
                lock <= 1'b0;
            end else if (lock_start) begin
                lock <= 1'b1;
            end

            if (act) begin
                if (smp.init) begin
                    state <= ARB_IDLE;
                    hold  <= '0;
                end else begin
                    unique case (state)
                        ARB_IDLE: begin
                            hold <= '0;
                            if (req_pending) state <= ARB_REQ;
                        end
                        ARB_REQ: begin
                            hold <= '0;
                            if (!req_pending)          state <= ARB_IDLE;
                            else if (!smp.prio || lock) state <= ARB_OWN;
                        end
                        ARB_OWN: begin
                            if (!req_pending) begin
                                state <= ARB_IDLE;
                                hold  <= '0;
                            end else if (blocked) begin
                                if (hold == HOLD_LAST) begin
                                    state <= ARB_REQ;
                                    hold  <= '0;
                                end else begin
                                    hold <= hold + 1'b1;
                                end
                            end else begin
                                grant <= 1'b1;
                                hold  <= '0;
                            end
                        end
                        default: begin
                            state <= ARB_IDLE;
                            hold  <= '0;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
    import issue_ctrl_pkg::*;
#(
    parameter int STROBE_DIV = 2,
    parameter int OQ_DEPTH   = 8,
    parameter int HOLD_LIMIT = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          init_obs_en,
    input  logic                          bus_init_n,
    input  logic                          stall_n,
    input  logic                          prio_n,
    input  logic                          req_pending,
    input  logic                          req_is_locked,
    input  logic                          lock_start,
    input  logic                          lock_end,
    input  logic                          cpl,
    output logic                          issue_grant,
    output logic [1:0]                    arb_state,
    output logic                          lock_active,
    output logic [$clog2(OQ_DEPTH+1)-1:0] oq_count
);
    logic       stb_w;
    logic       act_w;
    bus_smp_t   smp_w;
    logic       full_w;
    arb_state_e state_w;

    issue_strobe #(.STROBE_DIV(STROBE_DIV)) u_strobe (
        .clk (clk),
        .rst (rst),
        .stb (stb_w),
        .act (act_w)
    );

    issue_sampler u_sampler (
        .clk         (clk),
        .rst         (rst),
        .stb         (stb_w),
        .init_obs_en (init_obs_en),
        .bus_init_n  (bus_init_n),
        .stall_n     (stall_n),
        .prio_n      (prio_n),
        .smp         (smp_w)
    );

    issue_queue_ctr #(.OQ_DEPTH(OQ_DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .inc   (issue_grant),
        .dec   (cpl),
        .count (oq_count),
        .full  (full_w)
    );

    issue_arb #(.HOLD_LIMIT(HOLD_LIMIT)) u_arb (
        .clk           (clk),
        .rst           (rst),
        .act           (act_w),
        .smp           (smp_w),
        .req_pending   (req_pending),
        .req_is_locked (req_is_locked),
        .lock_start    (lock_start),
        .lock_end      (lock_end),
        .full          (full_w),
        .state         (state_w),
        .lock          (lock_active),
        .grant         (issue_grant)
    );

    assign arb_state = state_w;
endmodule

// File: rtl/issue_ctrl_checker.sv
module issue_ctrl_checker
    import issue_ctrl_pkg::*;
#(
    parameter int OQ_DEPTH = 8,
    localparam int CW = $clog2(OQ_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          act,
    input bus_smp_t      smp,
    input logic          req_is_locked,
    input logic          cpl,
    input logic          issue_grant,
    input logic [1:0]    arb_state,
    input logic          lock_active,
    input logic [CW-1:0] oq_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        oq_count <= CW'(OQ_DEPTH)); // R8

    AST_INIT_IDLES: assert property (@(posedge clk) disable iff (rst)
        (act && smp.init) |=> (arb_state == 2'd0 && !lock_active)); // R3

    AST_INIT_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (rst)
        (act && smp.init && !cpl && !issue_grant) |=> $stable(oq_count)); // R4

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        issue_grant |-> !smp.stall); // R6

    AST_PRIO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        issue_grant |-> ($past(!smp.prio) || ($past(lock_active) && $past(req_is_locked)))); // R7

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
        issue_grant |=> !issue_grant); // R12

    AST_GRANT_IN_OWNER: assert property (@(posedge clk) disable iff (rst)
        issue_grant |-> arb_state == 2'd2); // R12
endmodule

bind issue_ctrl issue_ctrl_checker #(.OQ_DEPTH(OQ_DEPTH)) u_issue_ctrl_checker (
    .clk           (clk),
    .rst           (rst),
    .act           (act_w),
    .smp           (smp_w),
    .req_is_locked (req_is_locked),
    .cpl           (cpl),
    .issue_grant   (issue_grant),
    .arb_state     (arb_state),
    .lock_active   (lock_active),
    .oq_count      (oq_count)
);

// File: tb/issue_ctrl_bench.sv
module issue_ctrl_bench;
    localparam int DIV   = 3;
    localparam int DEPTH = 4;
    localparam int HOLD  = 3;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_obs_en = 1'b1, bus_init_n = 1'b1, stall_n = 1'b1, prio_n = 1'b1;
    logic req_pending = 1'b0, req_is_locked = 1'b0, lock_start = 1'b0, lock_end = 1'b0, cpl = 1'b0;
    logic          issue_grant;
    logic [1:0]    arb_state;
    logic          lock_active;
    logic [CW-1:0] oq_count;

    int total = 0, bad = 0, cyc = 0, gcnt = 0, last_g = 0;
    logic saw_req = 1'b0;
    logic model_on = 1'b0;

    always #10 clk = ~clk;

    issue_ctrl #(.STROBE_DIV(DIV), .OQ_DEPTH(DEPTH), .HOLD_LIMIT(HOLD)) u_issue_ctrl (
        .clk(clk), .rst(rst), .init_obs_en(init_obs_en), .bus_init_n(bus_init_n),
        .stall_n(stall_n), .prio_n(prio_n), .req_pending(req_pending),
        .req_is_locked(req_is_locked), .lock_start(lock_start), .lock_end(lock_end),
        .cpl(cpl), .issue_grant(issue_grant), .arb_state(arb_state),
        .lock_active(lock_active), .oq_count(oq_count)
    );

    task automatic chk(input logic ok, input string req, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act_v, exp_v, cyc);
        end
    endtask

    // Bench model of the requirements
    int   m_c, m_h, m_q;
    logic m_act, m_si, m_ss, m_sp, m_lk, m_g;
    logic [1:0] m_st;

    always @(posedge clk) begin
        logic stb, blk;
        if (rst) begin
            m_c <= 0; m_h <= 0; m_q <= 0; m_act <= 0;
            m_si <= 0; m_ss <= 0; m_sp <= 0; m_lk <= 0; m_g <= 0; m_st <= 2'd0;
        end else begin
            stb = (m_c == DIV - 1);
            blk = m_ss | (m_sp & !(m_lk & req_is_locked)) | (m_q == DEPTH);
            m_c   <= stb ? 0 : m_c + 1;
            m_act <= stb;
            if (stb) begin
                m_si <= init_obs_en & !bus_init_n;
                m_ss <= !stall_n;
                m_sp <= !prio_n;
            end
            if (m_g && !cpl && m_q < DEPTH) m_q <= m_q + 1;
            else if (!m_g && cpl && m_q > 0) m_q <= m_q - 1;
            m_g <= 1'b0;
            if (m_act && m_si) m_lk <= 1'b0;
            else if (lock_end) m_lk <= 1'b0;
            else if (lock_start) m_lk <= 1'b1;
            if (m_act) begin
                if (m_si) begin
                    m_st <= 2'd0; m_h <= 0;
                end else if (m_st == 2'd0) begin
                    if (req_pending) m_st <= 2'd1;
                end else if (m_st == 2'd1) begin
                    if (!req_pending) m_st <= 2'd0;
                    else if (!m_sp || m_lk) m_st <= 2'd2;
                end else begin
                    if (!req_pending) begin
                        m_st <= 2'd0; m_h <= 0;
                    end else if (blk) begin
                        if (m_h == HOLD - 1) begin
                            m_st <= 2'd1; m_h <= 0;
                        end else m_h <= m_h + 1;
                    end else begin
                        m_g <= 1'b1; m_h <= 0;
                    end
                end
            end
        end
    end

    // Monitor at the falling edge
    logic prev_g = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (issue_grant) gcnt++;
            if (arb_state == 2'd1 && req_pending) saw_req = 1'b1;
            if (issue_grant && prev_g) chk(1'b0, "R12 grant longer than one cycle", 1, 0);
            if (model_on) begin
                chk(issue_grant == m_g, "R12 grant vs model", int'(issue_grant), int'(m_g));
                chk(arb_state == m_st, "R9 state vs model", int'(arb_state), int'(m_st));
                chk(lock_active == m_lk, "R11 lock vs model", int'(lock_active), int'(m_lk));
                chk(int'(oq_count) == m_q, "R8 count vs model", int'(oq_count), m_q);
            end
        end
        prev_g = issue_grant;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_lock_start();
        lock_start = 1'b1; step(1); lock_start = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        step(100000);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int g0, t1, t2;
        void'($urandom(32'h1234));
        step(3);
        rst = 1'b0;
        model_on = 1'b1;
        // R1 reset values
        chk(issue_grant == 1'b0, "R1 grant after reset", int'(issue_grant), 0);
        chk(arb_state == 2'd0, "R1 state after reset", int'(arb_state), 0);
        chk(lock_active == 1'b0, "R1 lock after reset", int'(lock_active), 0);
        chk(oq_count == '0, "R1 count after reset", int'(oq_count), 0);

        // R2 grant spacing equals strobe period
        req_pending = 1'b1; cpl = 1'b1;
        step(6 * DIV);
        while (!issue_grant) step(1);
        t1 = cyc; step(1);
        while (!issue_grant) step(1);
        t2 = cyc;
        chk(t2 - t1 == DIV, "R2 grant spacing", t2 - t1, DIV);

        // R8 fill the queue, then no more grants
        cpl = 1'b0;
        step(12 * DIV);
        chk(int'(oq_count) == DEPTH, "R8 queue fills", int'(oq_count), DEPTH);
        g0 = gcnt; step(10 * DIV);
        chk(gcnt == g0, "R8 no grant when full", gcnt - g0, 0);
        chk(int'(oq_count) == DEPTH, "R8 saturates", int'(oq_count), DEPTH);

        // R11 lock set, end wins over start
        pulse_lock_start(); step(1);
        chk(lock_active == 1'b1, "R11 lock set", int'(lock_active), 1);
        lock_start = 1'b1; lock_end = 1'b1; step(1);
        lock_start = 1'b0; lock_end = 1'b0; step(1);
        chk(lock_active == 1'b0, "R11 end wins", int'(lock_active), 0);
        pulse_lock_start(); step(1);

        // R2 glitch between capture edges is ignored
        while (m_c != 0) step(1);
        bus_init_n = 1'b0; step(1); bus_init_n = 1'b1;
        step(2 * DIV);
        chk(lock_active == 1'b1, "R2 glitch ignored", int'(lock_active), 1);

        // R5 strap off: init has no effect
        init_obs_en = 1'b0; bus_init_n = 1'b0; step(3 * DIV);
        chk(lock_active == 1'b1, "R5 lock kept with strap off", int'(lock_active), 1);
        chk(int'(oq_count) == DEPTH, "R5 count kept with strap off", int'(oq_count), DEPTH);
        bus_init_n = 1'b1; init_obs_en = 1'b1; step(DIV);

        // R3 and R4 init clears lock, keeps full queue
        bus_init_n = 1'b0; step(DIV); bus_init_n = 1'b1; step(DIV + 1);
        chk(lock_active == 1'b0, "R3 init clears lock", int'(lock_active), 0);
        chk(int'(oq_count) == DEPTH, "R4 init keeps queue", int'(oq_count), DEPTH);

        // R10 grants resume after init once completions arrive
        cpl = 1'b1; g0 = gcnt; step(12 * DIV);
        chk(gcnt > g0, "R10 grants resume after init", gcnt - g0, 1);

        // R6 stall blocks and R9 falls back to requesting
        stall_n = 1'b0; step(DIV + 1);
        g0 = gcnt; saw_req = 1'b0; step(12 * DIV);
        chk(gcnt == g0, "R6 no grant under stall", gcnt - g0, 0);
        chk(saw_req == 1'b1, "R9 owner falls back to requesting", int'(saw_req), 1);
        stall_n = 1'b1; step(4 * DIV);

        // R7 priority blocks unless locked request
        prio_n = 1'b0; step(DIV + 1);
        g0 = gcnt; step(12 * DIV);
        chk(gcnt == g0, "R7 priority blocks issue", gcnt - g0, 0);
        prio_n = 1'b1; step(DIV);
        pulse_lock_start(); req_is_locked = 1'b1; step(3 * DIV);
        prio_n = 1'b0; step(DIV + 1);
        g0 = gcnt; step(12 * DIV);
        chk(gcnt > g0, "R7 locked request passes priority", gcnt - g0, 1);
        prio_n = 1'b1; req_is_locked = 1'b0; lock_end = 1'b1; step(1); lock_end = 1'b0;

        // Random segments against the model
        for (int seg = 0; seg < 8; seg++) begin
            init_obs_en = $urandom_range(0, 3) != 0;
            for (int i = 0; i < 400; i++) begin
                req_pending   = $urandom_range(0, 7) != 0;
                req_is_locked = $urandom_range(0, 1);
                stall_n       = $urandom_range(0, 4) != 0;
                prio_n        = $urandom_range(0, 5) != 0;
                bus_init_n    = $urandom_range(0, 40) != 0;
                lock_start    = $urandom_range(0, 15) == 0;
                lock_end      = $urandom_range(0, 20) == 0;
                cpl           = $urandom_range(0, 2) == 0;
                step(1);
            end
        end
        step(2);
        finish_run();
    end
endmodule